// File: doc/BRIEF.md
# Full-Bit Directory Sharer Tracker

This block is the sharer-tracking part of a coherence directory. For each line of a small direct-mapped table it holds one presence bit per cache, plus an owner identifier with its own valid flag. A request port accepts shared reads, exclusive reads and invalidate-all commands. An update port accepts unblock messages (shared or modified) and writebacks. The block does not probe every cache. It sends a multicast to the recorded sharers only, and for reads that multicast excludes the requestor. The block also tells the requestor how many acknowledgements will never arrive, so that the requestor's completion counting works the same way it would under a full broadcast.

Each read produces up to two registered messages, each with a valid/ready handshake. The forward message carries the multicast destination mask and a flag that marks it as an invalidation. The response message carries the ack weight, the silent-ack count and the data kind (shared or exclusive). Protocol violations, such as a writeback from a cache that holds no copy, raise a one-cycle error pulse. Memory data, the network and replacement are handled elsewhere.

Top module: `dir_sharer_tracker`

## Requirements
- R1: After reset both output valids and the error pulse are low, the request port is ready, and every line holds an empty sharer vector with no owner.
- R2: For a shared read (kind 0) or an exclusive read (kind 1), the forward set is the line's sharer vector with the requestor's bit cleared. A forward message (fwd_inval=0) is issued only when that set is non-empty, and its mask equals the set.
- R3: When the forward set is non-empty, the response has rsp_excl=0, an ack weight of 1, and a silent count of N_CACHES minus the popcount of the forward set minus 1.
- R4: When the forward set is empty, the response has rsp_excl=1, an ack weight of N_CACHES and a silent count of 0.
- R5: An unblock-modified update (kind 1) makes the sender the owner and sets the sharer vector to the sender's bit alone.
- R6: An unblock-shared update (kind 0) sets the sender's bit and leaves the other bits unchanged.
- R7: An exclusive read sets the sharer vector to the requestor's bit alone and clears the owner.
- R8: A writeback (update kind 2) clears the sender's bit, and clears the owner if the sender was the owner. A writeback from a cache whose bit is clear changes nothing and raises the error pulse.
- R9: Invalidate-all (request kind 2) on a non-empty vector sends a forward with fwd_inval=1 and a mask equal to the whole vector. Its response has rsp_inval=1 and an ack count equal to the popcount of the vector, and the vector itself is unchanged. On an empty vector the command produces no message and raises the error pulse.
- R10: A shared read to a line that has an owner raises the error pulse when the requestor is the owner or a current sharer. The read is still answered. Reserved kinds (3) raise the error pulse and have no other effect.
- R11: Each output holds its valid and its fields stable until it is taken by ready. The request port is not ready while either output is pending or while an update is offered. Updates are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_idx | input | IDX_W | Line index of the request |
| req_src | input | ID_W | Requesting cache |
| req_kind | input | 2 | 0 shared read, 1 exclusive read, 2 invalidate-all |
| upd_valid | input | 1 | Update offered (always accepted) |
| upd_ready | output | 1 | Constant 1 |
| upd_idx | input | IDX_W | Line index of the update |
| upd_src | input | ID_W | Sending cache |
| upd_kind | input | 2 | 0 unblock shared, 1 unblock modified, 2 writeback |
| fwd_valid | output | 1 | Forward message pending |
| fwd_ready | input | 1 | Forward message taken |
| fwd_mask | output | N_CACHES | Multicast destination mask |
| fwd_inval | output | 1 | Forward is an invalidation |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response taken |
| rsp_acks | output | CNT_W | Ack weight, or the pending count for invalidate-all |
| rsp_silent | output | CNT_W | Number of acks that will never arrive |
| rsp_excl | output | 1 | Exclusive data kind |
| rsp_inval | output | 1 | Response belongs to invalidate-all |
| err | output | 1 | One-cycle protocol-violation pulse |

## Verification
The assertions check the output-port rules on every cycle. They confirm that the requestor never appears in its own forward mask, that a forward mask is never empty, that the ack and silent counts agree with the popcount of the mask issued alongside them, and that pending messages hold steady and block new requests. They cannot see the sharer table itself. The update rules (unblock, writeback, exclusive reset, owner tracking) can only be shown by the bench's scenarios, which build every sharer subset on a line, read it from every requestor, and compare the masks and counts against values computed arithmetically.

// File: rtl/dir_sharer_pkg.sv
`timescale 1ns/1ps
package dir_sharer_pkg;
  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_EXCL  = 2'd1,
    RQ_INVAL = 2'd2,
    RQ_RSVD  = 2'd3
  } rq_kind_e;

  typedef enum logic [1:0] {
    UP_SHARED = 2'd0,
    UP_MOD    = 2'd1,
    UP_WB     = 2'd2,
    UP_RSVD   = 2'd3
  } up_kind_e;
endpackage

// File: rtl/dir_popcnt.sv
`timescale 1ns/1ps
module dir_popcnt #(
  parameter int W  = 4,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/dir_line_ram.sv
`timescale 1ns/1ps
module dir_line_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dir_fwd_calc.sv
`timescale 1ns/1ps
module dir_fwd_calc #(
  parameter int N_CACHES = 4,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int CNT_W   = $clog2(N_CACHES + 1)
) (
  input  logic [N_CACHES-1:0] sharers,
  input  logic [ID_W-1:0]     requestor,
  output logic [N_CACHES-1:0] fwd_set,
  output logic [CNT_W-1:0]    fwd_cnt,
  output logic [CNT_W-1:0]    sh_cnt
);
  logic [N_CACHES-1:0] req_bit;

  assign req_bit = {{(N_CACHES-1){1'b0}}, 1'b1} << requestor;
  assign fwd_set = sharers & ~req_bit;

  dir_popcnt #(.W(N_CACHES), .CW(CNT_W)) u_pop_fwd (.vec(fwd_set), .cnt(fwd_cnt));
  dir_popcnt #(.W(N_CACHES), .CW(CNT_W)) u_pop_sh  (.vec(sharers), .cnt(sh_cnt));
endmodule

// File: rtl/dir_sharer_tracker.sv
`timescale 1ns/1ps
module dir_sharer_tracker #(
  parameter int N_CACHES = 4,
  parameter int LINES    = 16,
  localparam int ID_W    = $clog2(N_CACHES),
  localparam int IDX_W   = $clog2(LINES),
  localparam int CNT_W   = $clog2(N_CACHES + 1),
  localparam int ENT_W   = 1 + ID_W + N_CACHES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic [ID_W-1:0]     req_src,
  input  logic [1:0]          req_kind,
  input  logic                upd_valid,
  output logic                upd_ready,
  input  logic [IDX_W-1:0]    upd_idx,
  input  logic [ID_W-1:0]     upd_src,
  input  logic [1:0]          upd_kind,
  output logic                fwd_valid,
  input  logic                fwd_ready,
  output logic [N_CACHES-1:0] fwd_mask,
  output logic                fwd_inval,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [CNT_W-1:0]    rsp_acks,
  output logic [CNT_W-1:0]    rsp_silent,
  output logic                rsp_excl,
  output logic                rsp_inval,
  output logic                err
);
  import dir_sharer_pkg::*;

  // line table: {owner valid, owner id, sharer bits}
  logic [LINES-1:0]    line_vld;
  logic [IDX_W-1:0]    line_idx;
  logic [ENT_W-1:0]    ram_q, cur, nxt;
  logic                wr_en;

  logic [N_CACHES-1:0] cur_sh, nxt_sh;
  logic [ID_W-1:0]     cur_own, nxt_own;
  logic                cur_ov, nxt_ov;

  logic [ID_W-1:0]     src;
  logic [N_CACHES-1:0] src_bit;
  logic [N_CACHES-1:0] fwd_set;
  logic [CNT_W-1:0]    fwd_cnt, sh_cnt;

  logic                viol;
  logic                n_fwd_v, n_fwd_inv, n_rsp_v, n_excl, n_rinv;
  logic [N_CACHES-1:0] n_mask;
  logic [CNT_W-1:0]    n_acks, n_sil;

  assign upd_ready = 1'b1;
  assign req_ready = !upd_valid && !fwd_valid && !rsp_valid;

  assign line_idx = upd_valid ? upd_idx : req_idx;
  assign src      = upd_valid ? upd_src : req_src;
  assign src_bit  = {{(N_CACHES-1){1'b0}}, 1'b1} << src;

  dir_line_ram #(.DEPTH(LINES), .WIDTH(ENT_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (line_idx),
    .wdata (nxt),
    .raddr (line_idx),
    .rdata (ram_q)
  );

  assign cur     = line_vld[line_idx] ? ram_q : '0;
  assign cur_sh  = cur[N_CACHES-1:0];
  assign cur_own = cur[N_CACHES +: ID_W];
  assign cur_ov  = cur[ENT_W-1];
  assign nxt     = {nxt_ov, nxt_own, nxt_sh};

  dir_fwd_calc #(.N_CACHES(N_CACHES)) u_calc (
    .sharers   (cur_sh),
    .requestor (req_src),
    .fwd_set   (fwd_set),
    .fwd_cnt   (fwd_cnt),
    .sh_cnt    (sh_cnt)
  );

  always_comb begin
    nxt_sh    = cur_sh;
    nxt_own   = cur_own;
    nxt_ov    = cur_ov;
    wr_en     = 1'b0;
    viol      = 1'b0;
    n_fwd_v   = 1'b0;
    n_fwd_inv = 1'b0;
    n_mask    = fwd_set;
    n_rsp_v   = 1'b0;
    n_acks    = '0;
    n_sil     = '0;
    n_excl    = 1'b0;
    n_rinv    = 1'b0;
    if (upd_valid) begin
      unique case (up_kind_e'(upd_kind))
        UP_SHARED: begin
          wr_en  = 1'b1;
          nxt_sh = cur_sh | src_bit;
        end
        UP_MOD: begin
          wr_en   = 1'b1;
          nxt_sh  = src_bit;
          nxt_own = upd_src;
          nxt_ov  = 1'b1;
        end
        UP_WB: begin
          if ((cur_sh & src_bit) == '0) begin
            viol = 1'b1;
          end else begin
            wr_en  = 1'b1;
            nxt_sh = cur_sh & ~src_bit;
            if (cur_ov && cur_own == upd_src) nxt_ov = 1'b0;
          end
        end
        default: viol = 1'b1;
      endcase
    end else if (req_valid && req_ready) begin
      unique case (rq_kind_e'(req_kind))
        RQ_READ, RQ_EXCL: begin
          n_rsp_v = 1'b1;
          if (fwd_set != '0) begin
            n_fwd_v = 1'b1;
            n_acks  = CNT_W'(1);
            n_sil   = CNT_W'(N_CACHES) - fwd_cnt - CNT_W'(1);
          end else begin
            n_acks = CNT_W'(N_CACHES);
            n_excl = 1'b1;
          end
          if (rq_kind_e'(req_kind) == RQ_READ) begin
            viol = cur_ov && ((cur_own == req_src) || ((cur_sh & src_bit) != '0));
          end else begin
            wr_en  = 1'b1;
            nxt_sh = src_bit;
            nxt_ov = 1'b0;
          end
        end
        RQ_INVAL: begin
          if (cur_sh == '0) begin
            viol = 1'b1;
          end else begin
            n_fwd_v   = 1'b1;
            n_fwd_inv = 1'b1;
            n_mask    = cur_sh;
            n_rsp_v   = 1'b1;
            n_acks    = sh_cnt;
            n_rinv    = 1'b1;
          end
        end
        default: viol = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_vld   <= '0;
      err        <= 1'b0;
      fwd_valid  <= 1'b0;
      fwd_mask   <= '0;
      fwd_inval  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_acks   <= '0;
      rsp_silent <= '0;
      rsp_excl   <= 1'b0;
      rsp_inval  <= 1'b0;
    end else begin
      err <= viol;
      if (wr_en) line_vld[line_idx] <= 1'b1;
      if (fwd_valid && fwd_ready) fwd_valid <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (n_fwd_v) begin
        fwd_valid <= 1'b1;
        fwd_mask  <= n_mask;
        fwd_inval <= n_fwd_inv;
      end
      if (n_rsp_v) begin
        rsp_valid  <= 1'b1;
        rsp_acks   <= n_acks;
        rsp_silent <= n_sil;
        rsp_excl   <= n_excl;
        rsp_inval  <= n_rinv;
      end
    end
  end
endmodule

// File: rtl/dir_sharer_tracker_chk.sv
`timescale 1ns/1ps
module dir_sharer_tracker_chk #(
  parameter int N_CACHES = 4,
  parameter int ID_W     = 2,
  parameter int CNT_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ID_W-1:0]     req_src,
  input logic [1:0]          req_kind,
  input logic                upd_valid,
  input logic                upd_ready,
  input logic                fwd_valid,
  input logic                fwd_ready,
  input logic [N_CACHES-1:0] fwd_mask,
  input logic                fwd_inval,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [CNT_W-1:0]    rsp_acks,
  input logic [CNT_W-1:0]    rsp_silent,
  input logic                rsp_excl,
  input logic                rsp_inval
);
  a_r2_requestor_not_probed: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_kind != 2'd2) |=> !(fwd_valid && fwd_mask[$past(req_src)]));

  a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (fwd_mask != '0));

  a_r3_shared_counts: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && fwd_valid && !rsp_inval) |->
      (!rsp_excl && rsp_acks == CNT_W'(1) &&
       (32'(rsp_silent) + $countones(fwd_mask) == N_CACHES - 1)));

  a_r4_exclusive_counts: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_excl) |-> (!rsp_inval && rsp_acks == CNT_W'(N_CACHES) && rsp_silent == '0));

  a_r9_inval_count: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_inval && fwd_valid) |-> (fwd_inval && 32'(rsp_acks) == $countones(fwd_mask)));

  a_r11_fwd_hold: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_mask) && $stable(fwd_inval)));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_acks) && $stable(rsp_silent) &&
                                   $stable(rsp_excl) && $stable(rsp_inval)));

  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid || rsp_valid || upd_valid) |-> !req_ready);

  a_r11_upd_always: assert property (@(posedge clk) disable iff (rst)
    upd_ready);
endmodule

bind dir_sharer_tracker dir_sharer_tracker_chk #(
  .N_CACHES (N_CACHES),
  .ID_W     (ID_W),
  .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/dir_sharer_tracker_tb.sv
`timescale 1ns/1ps
module dir_sharer_tracker_tb;
  localparam int N  = 4;
  localparam int L  = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_ready;
  logic [3:0] req_idx;
  logic [1:0] req_src, req_kind;
  logic       upd_valid, upd_ready;
  logic [3:0] upd_idx;
  logic [1:0] upd_src, upd_kind;
  logic       fwd_valid, fwd_ready, fwd_inval;
  logic [3:0] fwd_mask;
  logic       rsp_valid, rsp_ready, rsp_excl, rsp_inval;
  logic [2:0] rsp_acks, rsp_silent;
  logic       err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit s_err, s_fv, s_fi, s_rv, s_rx, s_ri;
  int s_fm, s_ra, s_rs;

  always #2.5 clk = ~clk;

  dir_sharer_tracker #(.N_CACHES(N), .LINES(L)) u_dut (
    .clk, .rst, .req_valid, .req_ready, .req_idx, .req_src, .req_kind,
    .upd_valid, .upd_ready, .upd_idx, .upd_src, .upd_kind,
    .fwd_valid, .fwd_ready, .fwd_mask, .fwd_inval,
    .rsp_valid, .rsp_ready, .rsp_acks, .rsp_silent, .rsp_excl, .rsp_inval, .err
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pop(input int v);
    int c = 0;
    for (int i = 0; i < N; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic capture();
    s_err = err; s_fv = fwd_valid; s_fm = fwd_mask; s_fi = fwd_inval;
    s_rv = rsp_valid; s_ra = rsp_acks; s_rs = rsp_silent; s_rx = rsp_excl; s_ri = rsp_inval;
  endtask

  task automatic drain();
    fwd_ready = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0; rsp_ready = 1'b0;
  endtask

  task automatic send_req(input int idx, input int src, input int kind, input bit do_drain);
    @(negedge clk);
    req_idx = 4'(idx); req_src = 2'(src); req_kind = 2'(kind); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    capture();
    if (do_drain) drain();
  endtask

  task automatic send_upd(input int idx, input int src, input int kind);
    @(negedge clk);
    upd_idx = 4'(idx); upd_src = 2'(src); upd_kind = 2'(kind); upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    s_err = err;
  endtask

  // leave line with exactly sharer set s and no owner
  task automatic build_set(input int idx, input int s);
    send_req(idx, 0, 1, 1);
    send_upd(idx, 0, 2);
    for (int b = 0; b < N; b++) if ((s >> b) & 1) send_upd(idx, b, 0);
  endtask

  task automatic check_read(input string tag, input int s, input int q);
    int f = s & ~(1 << q);
    if (f != 0) begin
      chk(s_fv == 1 && s_fi == 0, {tag, " fwd valid"}, s_fv, 1);
      chk(s_fm == f, {tag, " fwd mask"}, s_fm, f);
      chk(s_ra == 1 && s_rx == 0, {tag, " acks"}, s_ra, 1);
      chk(s_rs == N - pop(f) - 1, {tag, " silent"}, s_rs, N - pop(f) - 1);
    end else begin
      chk(s_fv == 0, {tag, " no fwd"}, s_fv, 0);
      chk(s_ra == N && s_rx == 1, {tag, " excl acks"}, s_ra, N);
      chk(s_rs == 0, {tag, " excl silent"}, s_rs, 0);
    end
    chk(s_rv == 1 && s_ri == 0, {tag, " rsp valid"}, s_rv, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 0; upd_valid = 0; fwd_ready = 0; rsp_ready = 0;
    req_idx = 0; req_src = 0; req_kind = 0; upd_idx = 0; upd_src = 0; upd_kind = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(fwd_valid == 0 && rsp_valid == 0, "R1 outputs idle", fwd_valid + rsp_valid, 0);
    chk(err == 0, "R1 err low", err, 0);
    chk(req_ready == 1, "R1 req ready", req_ready, 1);
    send_req(5, 2, 0, 1);
    check_read("R1 fresh line R4", 0, 2);
    chk(s_err == 0, "R1 no err", s_err, 0);

    // R2 R3 R4 R6 sweep over every sharer set and requestor, both read kinds
    for (int s = 0; s < 16; s++) begin
      for (int q = 0; q < N; q++) begin
        build_set(3, s);
        send_req(3, q, 0, 1);
        check_read("R2 R3 R6 shared read", s, q);
        chk(s_err == 0, "R6 no err without owner", s_err, 0);
      end
    end
    for (int s = 0; s < 16; s += 5) begin
      for (int q = 0; q < N; q++) begin
        build_set(7, s);
        send_req(7, q, 1, 1);
        check_read("R2 R4 exclusive read", s, q);
        // R7: vector is now only q
        send_req(7, (q + 1) % N, 0, 1);
        check_read("R7 after exclusive", 1 << q, (q + 1) % N);
      end
    end

    // R9 invalidate-all over every set
    for (int s = 0; s < 16; s++) begin
      build_set(9, s);
      send_req(9, 1, 2, 1);
      if (s != 0) begin
        chk(s_fv && s_fi && s_fm == s, "R9 inval mask", s_fm, s);
        chk(s_rv && s_ri && s_ra == pop(s), "R9 inval pending", s_ra, pop(s));
        chk(s_err == 0, "R9 no err", s_err, 0);
        send_req(9, 3, 0, 1);
        check_read("R9 vector kept", s, 3);
      end else begin
        chk(!s_fv && !s_rv, "R9 empty no msg", s_fv + s_rv, 0);
        chk(s_err == 1, "R9 empty err", s_err, 1);
      end
    end

    // R5 unblock modified, R10 owner checks
    build_set(11, 4'b0011);
    send_upd(11, 2, 1);
    send_req(11, 3, 0, 1);
    check_read("R5 owner only", 4'b0100, 3);
    chk(s_err == 0, "R10 non-owner read ok", s_err, 0);
    send_req(11, 2, 0, 1);
    chk(s_err == 1, "R10 owner reread err", s_err, 1);
    chk(s_rv == 1, "R10 still answered", s_rv, 1);
    send_upd(11, 3, 0);
    send_req(11, 3, 0, 1);
    chk(s_err == 1, "R10 sharer reread err", s_err, 1);
    // R8 writeback by owner clears bit and owner
    send_upd(11, 2, 2);
    chk(s_err == 0, "R8 wb ok", s_err, 0);
    send_upd(11, 3, 2);
    send_req(11, 2, 0, 1);
    chk(s_err == 0, "R8 owner cleared", s_err, 0);
    check_read("R8 bits cleared", 0, 2);
    // R8 writeback without copy
    build_set(12, 4'b0001);
    send_upd(12, 2, 2);
    chk(s_err == 1, "R8 stray wb err", s_err, 1);
    send_req(12, 3, 0, 1);
    check_read("R8 stray wb no change", 4'b0001, 3);
    // R10 reserved kinds
    send_upd(12, 1, 3);
    chk(s_err == 1, "R10 reserved update err", s_err, 1);
    send_req(12, 1, 3, 1);
    chk(s_err == 1 && !s_fv && !s_rv, "R10 reserved req no msg", s_fv + s_rv, 0);
    send_req(12, 3, 0, 1);
    check_read("R10 reserved no change", 4'b0001, 3);

    // R11 update priority and output hold
    build_set(13, 4'b0110);
    @(negedge clk);
    upd_idx = 4'd14; upd_src = 2'd0; upd_kind = 2'd0; upd_valid = 1'b1;
    req_idx = 4'd13; req_src = 2'd0; req_kind = 2'd0; req_valid = 1'b1;
    #1;
    chk(req_ready == 0, "R11 update wins", req_ready, 0);
    @(negedge clk);
    upd_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    capture();
    chk(s_fv && s_fm == 4'b0110, "R11 delayed request", s_fm, 6);
    repeat (3) @(negedge clk);
    chk(fwd_valid && fwd_mask == 4'(s_fm), "R11 fwd held", fwd_mask, s_fm);
    chk(rsp_valid && rsp_acks == 3'(s_ra) && rsp_silent == 3'(s_rs), "R11 rsp held", rsp_silent, s_rs);
    chk(req_ready == 0, "R11 busy not ready", req_ready, 0);
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    chk(!fwd_valid && rsp_valid, "R11 independent drain", fwd_valid, 0);
    drain();
    chk(!rsp_valid && req_ready, "R11 drained", req_ready, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule